// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit Error Checker

This block takes a serial bit stream that carries a pseudo-random pattern and counts the bit errors in it. It keeps its own copy of the pattern generator's shift register. While it is searching for the pattern, the register is loaded from the incoming bits, so after a few bits it holds the same state as the far-end generator. Once a long stretch of bits has matched, the checker locks. In the locked state a multiplexer switches the register input to the locally computed feedback bit, so the register no longer depends on the line. Each corrupted line bit then gives exactly one error pulse, not one for every tap it later passes through.

While locked, the checker watches the error density over fixed windows of received bits. If too many errors occur in a window, it goes back to searching. Random data disagrees with the pattern about half the time, so the limit sits well below one half. Every error pulse seen while locked also increments a saturating counter, which the surrounding logic can clear. The pattern here is x^7 + x^6 + 1. Register width, taps, lock run, window length, window limit and counter width are all parameters.

Top module: `prbs_checker`

## Requirements
- R1: After reset `locked_o` is 0, `err_pulse_o` is 0 and `err_cnt_o` is 0.
- R2: The reference bit is the XOR of local register bits 5 and 6 (0-based). Each new bit enters at bit 0, which gives the pattern x^7 + x^6 + 1. A received bit is a mismatch when it differs from the reference bit. Only cycles with `rx_vld_i` high take part.
- R3: While unlocked, each valid bit is shifted into the local register. The checker locks on the 64th consecutive valid bit with no mismatch, and `locked_o` is 1 in the cycle after that bit.
- R4: While locked, the register is loaded from its own reference bit. A single inverted line bit gives exactly one `err_pulse_o`, high in the cycle after that bit. Later correct bits give no pulse, and cycles with `rx_vld_i` low have no effect.
- R5: While locked, valid bits are grouped into windows of 256, with the first window starting at the first valid bit after lock. A window with more than 64 mismatches drops `locked_o` in the cycle after its 256th bit. A window with exactly 64 mismatches keeps lock.
- R6: If the local register is all zeros while locked, `locked_o` falls in the next cycle.
- R7: `err_cnt_o` increments by one for each error pulse and holds at its all-ones maximum.
- R8: `cnt_clr_i` sets the count to 0 in the next cycle. If an error is counted in the same cycle as the clear, the count becomes 1.
- R9: Mismatches while unlocked produce no error pulse and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_vld_i | input | 1 | Qualifies rx_bit_i in this cycle |
| rx_bit_i | input | 1 | Received serial bit |
| cnt_clr_i | input | 1 | Synchronous clear of the error count |
| err_pulse_o | output | 1 | One-cycle pulse per mismatch while locked |
| locked_o | output | 1 | Checker is locked to the pattern |
| err_cnt_o | output | CNT_W | Saturating error count |

## Verification
The two functions that can land in the same cycle are the clear of the error count and the counting of a new error. The bench drives an inverted pattern bit with the clear held high while the checker is locked. It expects a count of exactly one afterwards, and then a clear alone gives zero. The end of a density window can also coincide with an error pulse. The bench aligns windows to the observed moment of lock, so the last bit of the 64-error and 65-error windows is judged for both its pulse and the lock state in the same sampled cycle.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
    typedef enum logic {
        MODE_HUNT  = 1'b0,
        MODE_TRACK = 1'b1
    } chk_mode_e;
endpackage

// File: rtl/prbs_shift_core.sv
module prbs_shift_core #(
    parameter int unsigned W     = 7,
    parameter int unsigned TAP_A = 6,
    parameter int unsigned TAP_B = 7
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vld_i,
    input  logic bit_i,
    input  logic track_i,
    output logic mis_o,
    output logic zero_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        ref_bit;

    // Reference bit from the two generator taps, mismatch against the line.
    always_comb begin
        ref_bit = st_q.sr[TAP_A-1] ^ st_q.sr[TAP_B-1];
        mis_o   = bit_i ^ ref_bit;
        zero_o  = (st_q.sr == '0);
        st_d    = st_q;
        if (vld_i) begin
            // Input mux: line while hunting, own feedback while tracking.
            st_d.sr = {st_q.sr[W-2:0], (track_i ? ref_bit : bit_i)};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R6: a non-zero state never collapses to zero while self-fed.
    assert_track_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (track_i && vld_i && !zero_o) |=> !zero_o);
endmodule

// File: rtl/prbs_lock_ctrl.sv
module prbs_lock_ctrl
    import prbs_chk_pkg::*;
#(
    parameter int unsigned LOCK_RUN  = 64,
    parameter int unsigned WIN_LEN   = 256,
    parameter int unsigned WIN_LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vld_i,
    input  logic mis_i,
    input  logic zero_i,
    output logic track_o
);
    localparam int unsigned RUN_W = $clog2(LOCK_RUN);
    localparam int unsigned POS_W = $clog2(WIN_LEN);
    localparam int unsigned TAL_W = $clog2(WIN_LEN + 1);

    typedef struct packed {
        chk_mode_e        mode;
        logic [RUN_W-1:0] run;
        logic [POS_W-1:0] wpos;
        logic [TAL_W-1:0] tally;
    } ctrl_state_t;

    ctrl_state_t      st_d, st_q;
    logic [TAL_W-1:0] tally_nx;

    always_comb begin
        st_d     = st_q;
        tally_nx = st_q.tally + TAL_W'(mis_i);
        unique case (st_q.mode)
            MODE_HUNT: begin
                if (vld_i) begin
                    if (mis_i) begin
                        st_d.run = '0;
                    end else if (st_q.run == RUN_W'(LOCK_RUN - 1)) begin
                        st_d.mode  = MODE_TRACK;
                        st_d.run   = '0;
                        st_d.wpos  = '0;
                        st_d.tally = '0;
                    end else begin
                        st_d.run = st_q.run + 1'b1;
                    end
                end
            end
            MODE_TRACK: begin
                if (zero_i) begin
                    st_d.mode = MODE_HUNT;
                    st_d.run  = '0;
                end else if (vld_i) begin
                    if (st_q.wpos == POS_W'(WIN_LEN - 1)) begin
                        if (tally_nx > TAL_W'(WIN_LIMIT)) begin
                            st_d.mode = MODE_HUNT;
                            st_d.run  = '0;
                        end
                        st_d.wpos  = '0;
                        st_d.tally = '0;
                    end else begin
                        st_d.wpos  = st_q.wpos + 1'b1;
                        st_d.tally = tally_nx;
                    end
                end
            end
            default: st_d.mode = MODE_HUNT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: MODE_HUNT, run: '0, wpos: '0, tally: '0};
        else         st_q <= st_d;
    end

    assign track_o = (st_q.mode == MODE_TRACK);

    // R3: lock is only gained on a valid, matching bit.
    assert_lock_on_clean_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(track_o) |-> $past(vld_i && !mis_i));
    // R5/R6: lock is only lost on a window end or a zero register.
    assert_unlock_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(track_o) |-> $past(zero_i || vld_i));
endmodule

// File: rtl/prbs_err_tally.sv
module prbs_err_tally #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_state_t;

    tally_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)                   st_d.cnt = CNT_W'(inc_i);
        else if (inc_i && !(&st_q.cnt)) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R7: without a clear the count never goes down (no wrap).
    assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(clr_i) |-> (cnt_o >= $past(cnt_o)));
    // R7: the count moves by at most one per cycle.
    assert_single_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, cnt_o} <= ({1'b0, $past(cnt_o)} + 1'b1)));
    // R8: a clear leaves at most one.
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clr_i) |-> (cnt_o <= CNT_W'(1)));
endmodule

// File: rtl/prbs_checker.sv
module prbs_checker #(
    parameter int unsigned W         = 7,
    parameter int unsigned TAP_A     = 6,
    parameter int unsigned TAP_B     = 7,
    parameter int unsigned LOCK_RUN  = 64,
    parameter int unsigned WIN_LEN   = 256,
    parameter int unsigned WIN_LIMIT = 64,
    parameter int unsigned CNT_W     = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_vld_i,
    input  logic             rx_bit_i,
    input  logic             cnt_clr_i,
    output logic             err_pulse_o,
    output logic             locked_o,
    output logic [CNT_W-1:0] err_cnt_o
);
    typedef struct packed {
        logic pulse;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       mis, zero, track, hit;

    prbs_shift_core #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .vld_i   (rx_vld_i),
        .bit_i   (rx_bit_i),
        .track_i (track),
        .mis_o   (mis),
        .zero_o  (zero)
    );

    prbs_lock_ctrl #(.LOCK_RUN(LOCK_RUN), .WIN_LEN(WIN_LEN), .WIN_LIMIT(WIN_LIMIT)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .vld_i   (rx_vld_i),
        .mis_i   (mis),
        .zero_i  (zero),
        .track_o (track)
    );

    always_comb begin
        hit        = rx_vld_i && track && mis;
        st_d.pulse = hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    prbs_err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (hit),
        .clr_i  (cnt_clr_i),
        .cnt_o  (err_cnt_o)
    );

    assign err_pulse_o = st_q.pulse;
    assign locked_o    = track;

    // R9: a pulse always comes from a cycle spent locked.
    assert_pulse_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pulse_o |-> $past(locked_o));
    // R4: a pulse always comes from a valid bit.
    assert_pulse_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pulse_o |-> $past(rx_vld_i));
endmodule

// File: tb/sim_prbs_checker.sv
module sim_prbs_checker;
    localparam int CLK_P = 10;
    localparam int CW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld = 1'b0;
    logic          din = 1'b0;
    logic          clr = 1'b0;
    logic          pulse;
    logic          locked;
    logic [CW-1:0] cnt;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic [6:0] gen = 7'h01;
    logic exp_q[$];
    bit   due = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    prbs_checker #(.CNT_W(CW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .rx_vld_i(vld), .rx_bit_i(din),
        .cnt_clr_i(clr), .err_pulse_o(pulse), .locked_o(locked), .err_cnt_o(cnt)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    // Scoreboard monitor: one expected pulse value per pushed bit.
    always @(posedge clk) due <= vld && (exp_q.size() > 0);
    always @(negedge clk) begin
        if (due && exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            chk(pulse == e, "R4/R9 err_pulse", int'(pulse), int'(e));
        end
    end

    function automatic logic gen_step();
        logic b;
        b   = gen[6] ^ gen[5];
        gen = {gen[5:0], b};
        return b;
    endfunction

    // Drive one valid bit at a falling edge, return at the next falling edge.
    task automatic send(input logic b, input logic c);
        vld = 1'b1; din = b; clr = c;
        @(posedge clk);
        @(negedge clk);
        vld = 1'b0; clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            vld = 1'b0; din = ~din;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    // Pattern bit while locked, optionally inverted, with a scoreboard entry.
    task automatic lbit(input logic inj, input logic c, inout int wpos);
        logic g;
        g = gen_step();
        exp_q.push_back(inj);
        send(g ^ inj, c);
        wpos++;
    endtask

    initial begin
        int lock_at;
        int wpos;
        int errs;
        do_reset();
        chk(locked == 0 && pulse == 0 && cnt == 0, "R1 reset state",
            int'({locked, pulse, cnt}), 0);

        // All-zero stream: register stays zero, so no mismatches.
        for (int i = 0; i < 63; i++) send(1'b0, 1'b0);
        chk(locked == 0, "R3 not locked after 63 clean bits", int'(locked), 0);
        send(1'b0, 1'b0);
        chk(locked == 1, "R3 locked after 64th clean bit", int'(locked), 1);
        idle(1);
        chk(locked == 0, "R6 zero register drops lock", int'(locked), 0);
        chk(cnt == 0, "R7 no count during lockup", int'(cnt), 0);

        // Acquisition on the real pattern.
        do_reset();
        gen = 7'h01;
        lock_at = -1;
        for (int i = 1; i <= 100 && lock_at < 0; i++) begin
            send(gen_step(), 1'b0);
            if (locked) lock_at = i;
        end
        chk(lock_at >= 64 && lock_at <= 71, "R2/R3 lock point on pattern", lock_at, 64);

        wpos = 0; errs = 0;
        for (int i = 0; i < 40; i++) lbit(1'b0, 1'b0, wpos);
        chk(cnt == 0, "R2 clean pattern no count", int'(cnt), 0);
        idle(5);   // invalid cycles carry toggling data
        for (int i = 0; i < 10; i++) lbit(1'b0, 1'b0, wpos);
        chk(cnt == 0, "R4 invalid cycles ignored", int'(cnt), 0);
        lbit(1'b1, 1'b0, wpos); errs++;
        chk(pulse == 1, "R4 pulse in cycle after error", int'(pulse), 1);
        for (int i = 0; i < 20; i++) lbit(1'b0, 1'b0, wpos);
        chk(cnt == 1, "R4/R7 single error counted once", int'(cnt), 1);

        // Clear and count in the same cycle, then clear alone.
        lbit(1'b1, 1'b1, wpos); errs++;
        chk(cnt == 1, "R8 clear with error gives one", int'(cnt), 1);
        lbit(1'b0, 1'b1, wpos);
        chk(cnt == 0, "R8 clear alone gives zero", int'(cnt), 0);

        // Fill window 1 to exactly 64 errors.
        while (errs < 64) begin lbit(1'b1, 1'b0, wpos); errs++; end
        while (wpos < 256) lbit(1'b0, 1'b0, wpos);
        chk(locked == 1, "R5 exactly 64 errors keeps lock", int'(locked), 1);
        chk(cnt == {CW{1'b1}}, "R7 count saturates", int'(cnt), (1 << CW) - 1);

        // Window 2: 65 errors.
        for (int i = 0; i < 65; i++) lbit(1'b1, 1'b0, wpos);
        while (wpos < 511) lbit(1'b0, 1'b0, wpos);
        chk(locked == 1, "R5 locked before window end", int'(locked), 1);
        lbit(1'b0, 1'b0, wpos);
        chk(locked == 0, "R5 65 errors drops lock", int'(locked), 0);

        // Unlocked: errors give no pulse and no count.
        send(gen_step(), 1'b1);
        chk(cnt == 0, "R8 clear while unlocked", int'(cnt), 0);
        exp_q.push_back(1'b0);
        send(~gen_step(), 1'b0);
        chk(pulse == 0 && cnt == 0, "R9 unlocked error ignored", int'({pulse, cnt}), 0);

        idle(2);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule